// File: doc/BRIEF.md
# Extended Reach Supervisor

This block sits on the host side of a serial link to an adaptive cable receiver. It steers the receiver's reach mode. It reaches the receiver's registers only through a request/acknowledge command port. A separate SPI master, outside this block, serialises each command.

The supervisor reads two registers on a fixed poll interval:
- the general control register at address 00h, which holds the carrier bit;
- the cable-length register at address 03h.

Extended reach mode is turned on only when both of these hold:
- a carrier is present;
- the cable-length code is below a configurable limit.

Extended reach mode is turned off once the carrier is lost. Every switch follows a guarded three-step sequence:
1. Force the receiver to sleep.
2. Change the mode bit.
3. Hold for a minimum time, then restore the chosen sleep setting.

Two outputs report the mode in force and whether a sequence is running.

Top module: `erc_supervisor`

## Requirements
- R1: During and directly after reset, `cmd_req`, `ext_mode` and `busy` are 0, and the block starts in normal mode.
- R2: Each poll reads address 00h and then address 03h. At least `POLL_CYCLES` clocks pass between the end of a poll with no action (or the end of a sequence) and the next request to read 00h.
- R3: Entry is triggered when, in normal mode, the carrier bit (00h bit 7) reads 1 and the length code (03h bits 7:3) is strictly below `CLI_LIMIT` (default 18). A code equal to or above the limit, or a carrier of 0, leaves normal mode in place.
- R4: A sequence issues exactly three writes to 00h, in this order:
  - sleep field (bits 4:3) = 10 with the old mode bit (bit 2);
  - sleep field = 10 with the new mode bit;
  - sleep field = `RESTORE_SLEEP` (default 01) with the new mode bit.
- R5: At least `HOLD_CYCLES` clocks pass between the acknowledge of the mode-changing write and the request of the restoring write.
- R6: In extended mode, a carrier of 0 triggers the exit sequence. A long length code with the carrier present does not.
- R7: Every write keeps mute (bit 6) and bypass (bit 5) as they were returned by the latest read of 00h, and writes bit 7 and bits 1:0 as 0.
- R8: `ext_mode` equals the mode bit of the last acknowledged write. `busy` is 1 from the cycle before the first write of a sequence to the acknowledge of its restoring write, and 0 while polling.
- R9: A request holds address, direction and write data stable until it is acknowledged, and drops in the cycle after the acknowledge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cmd_req | output | 1 | Command request to the SPI master |
| cmd_write | output | 1 | 1 = write, 0 = read |
| cmd_addr | output | 7 | Register address |
| cmd_wdata | output | 8 | Write data |
| cmd_ack | input | 1 | One-cycle acknowledge from the SPI master |
| cmd_rdata | input | 8 | Read data, valid with `cmd_ack` on a read |
| ext_mode | output | 1 | 1 = receiver is in extended reach mode |
| busy | output | 1 | A switch sequence is in progress |

## Verification
Polling and a running sequence can overlap: the carrier may vanish while the receiver is held asleep in the middle of an entry.

The bench provokes this by clearing its carrier as soon as `busy` rises. The entry must still finish with all three writes and the full hold. The reference model then expects the next poll to return carrier 0 and an exit sequence to follow.

The cable-length limit is also tested at its boundary: a code of 18 must not trigger entry, while a code of 17 must.

// File: rtl/erc_pkg.sv
// Shared constants, register field positions and state type for the
// extended reach supervisor. Assumes 7-bit addresses and 8-bit registers.
package erc_pkg;
    localparam int REG_AW = 7;
    localparam int REG_DW = 8;

    localparam logic [REG_AW-1:0] ADDR_CTL = 7'h00;
    localparam logic [REG_AW-1:0] ADDR_CLI = 7'h03;

    localparam int CD_BIT   = 7;
    localparam int MUTE_BIT = 6;
    localparam int BYP_BIT  = 5;
    localparam int SLP_LSB  = 3;
    localparam int EXT_BIT  = 2;
    localparam int CLI_LSB  = 3;
    localparam int CLI_W    = 5;

    localparam logic [1:0] SLP_FORCE = 2'b10;

    typedef enum logic [2:0] {
        ST_POLL,
        ST_RD_CTL,
        ST_RD_CLI,
        ST_DECIDE,
        ST_WR_SLEEP,
        ST_WR_MODE,
        ST_HOLD,
        ST_WR_RESTORE
    } sup_state_t;

    // Build a control register write: read-only and reserved bits are zero.
    function automatic logic [REG_DW-1:0] pack_ctl(input logic mute,
                                                    input logic byp,
                                                    input logic [1:0] slp,
                                                    input logic ext);
        logic [REG_DW-1:0] v;
        v = '0;
        v[MUTE_BIT] = mute;
        v[BYP_BIT] = byp;
        v[SLP_LSB +: 2] = slp;
        v[EXT_BIT] = ext;
        return v;
    endfunction
endpackage

// File: rtl/erc_timer.sv
// Loadable down-counter used for the poll interval and the sleep hold.
// Assumes a load is never requested while the count is still needed.
module erc_timer #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic [W-1:0] value,
    output logic         zero
);
    logic [W-1:0] cnt_q;

    // Count down to zero; a load overrides the decrement.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (load) begin
            cnt_q <= value;
        end else if (cnt_q != '0) begin
            cnt_q <= cnt_q - 1'b1;
        end
    end

    assign zero = (cnt_q == '0);

    // R2
    tmr_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (load && value != '0) |=> !zero);
endmodule

// File: rtl/erc_cmd_port.sv
// Request/acknowledge holder toward the SPI master. A go pulse while idle
// launches one command; fields stay registered until the acknowledge.
// Assumes the master acknowledges each request with a single-cycle pulse.
module erc_cmd_port
    import erc_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              go,
    input  logic              go_write,
    input  logic [REG_AW-1:0] go_addr,
    input  logic [REG_DW-1:0] go_wdata,
    output logic              idle,
    output logic              done,
    output logic [REG_DW-1:0] rd_data,
    output logic              cmd_req,
    output logic              cmd_write,
    output logic [REG_AW-1:0] cmd_addr,
    output logic [REG_DW-1:0] cmd_wdata,
    input  logic              cmd_ack,
    input  logic [REG_DW-1:0] cmd_rdata
);
    logic              req_q;
    logic              wr_q;
    logic [REG_AW-1:0] addr_q;
    logic [REG_DW-1:0] wdata_q;

    // Raise the request on go and drop it after the acknowledge.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            req_q   <= 1'b0;
            wr_q    <= 1'b0;
            addr_q  <= '0;
            wdata_q <= '0;
        end else if (req_q && cmd_ack) begin
            req_q <= 1'b0;
        end else if (go) begin
            req_q   <= 1'b1;
            wr_q    <= go_write;
            addr_q  <= go_addr;
            wdata_q <= go_wdata;
        end
    end

    assign idle      = !req_q;
    assign done      = req_q && cmd_ack;
    assign rd_data   = cmd_rdata;
    assign cmd_req   = req_q;
    assign cmd_write = wr_q;
    assign cmd_addr  = addr_q;
    assign cmd_wdata = wdata_q;

    // R9
    req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_req && !cmd_ack) |=> (cmd_req && $stable(cmd_addr) &&
                                   $stable(cmd_wdata) && $stable(cmd_write)));
    // R9
    req_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_req && cmd_ack) |=> !cmd_req);
    // R9
    go_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        go |-> !req_q);
endmodule

// File: rtl/erc_decide.sv
// Mode decision from the latest poll. Entry needs carrier and a length
// code strictly under the limit; exit needs loss of carrier only.
module erc_decide #(
    parameter logic [4:0] CLI_LIMIT = 5'd18
) (
    input  logic       mode,
    input  logic       carrier,
    input  logic [4:0] cli,
    output logic       act,
    output logic       want
);
    logic go_ext;
    logic go_norm;

    // Combine the poll results with the current mode.
    always_comb begin
        go_ext  = !mode && carrier && (cli < CLI_LIMIT);
        go_norm = mode && !carrier;
        act     = go_ext || go_norm;
        want    = !mode;
    end
endmodule

// File: rtl/erc_supervisor.sv
// Extended reach supervisor: polls carrier and cable length through the
// command port and switches the receiver's reach mode with a
// sleep-guarded three-write sequence. Assumes the master answers every
// request and that register 00h bit 7 is read-only on the receiver.
module erc_supervisor
    import erc_pkg::*;
#(
    parameter logic [4:0]  CLI_LIMIT     = 5'd18,
    parameter logic [1:0]  RESTORE_SLEEP = 2'b01,
    parameter int unsigned POLL_CYCLES   = 1024,
    parameter int unsigned HOLD_CYCLES   = 250000
) (
    input  logic              clk,
    input  logic              rst_n,
    output logic              cmd_req,
    output logic              cmd_write,
    output logic [REG_AW-1:0] cmd_addr,
    output logic [REG_DW-1:0] cmd_wdata,
    input  logic              cmd_ack,
    input  logic [REG_DW-1:0] cmd_rdata,
    output logic              ext_mode,
    output logic              busy
);
    localparam int unsigned TMR_MAX = (POLL_CYCLES > HOLD_CYCLES) ? POLL_CYCLES : HOLD_CYCLES;
    localparam int TW = $clog2(TMR_MAX + 1);

    sup_state_t        state_q;
    logic              mode_q, tgt_q, carrier_q, mute_q, byp_q;
    logic [CLI_W-1:0]  cli_q;
    logic              issue, go, go_write, port_idle, done;
    logic [REG_AW-1:0] go_addr;
    logic [REG_DW-1:0] go_wdata, rd_data;
    logic              tmr_load, tmr_zero;
    logic [TW-1:0]     tmr_val;
    logic              act, want;
    logic              rd_unused;

    assign rd_unused = ^rd_data[2:0];

    erc_cmd_port u_port (
        .clk(clk), .rst_n(rst_n), .go(go), .go_write(go_write),
        .go_addr(go_addr), .go_wdata(go_wdata), .idle(port_idle),
        .done(done), .rd_data(rd_data), .cmd_req(cmd_req),
        .cmd_write(cmd_write), .cmd_addr(cmd_addr), .cmd_wdata(cmd_wdata),
        .cmd_ack(cmd_ack), .cmd_rdata(cmd_rdata)
    );

    erc_timer #(.W(TW)) u_tmr (
        .clk(clk), .rst_n(rst_n), .load(tmr_load), .value(tmr_val),
        .zero(tmr_zero)
    );

    erc_decide #(.CLI_LIMIT(CLI_LIMIT)) u_dec (
        .mode(mode_q), .carrier(carrier_q), .cli(cli_q),
        .act(act), .want(want)
    );

    // Pick the command for the current state and launch it when idle.
    always_comb begin
        issue    = 1'b0;
        go_write = 1'b0;
        go_addr  = ADDR_CTL;
        go_wdata = '0;
        unique case (state_q)
            ST_RD_CTL: issue = 1'b1;
            ST_RD_CLI: begin
                issue   = 1'b1;
                go_addr = ADDR_CLI;
            end
            ST_WR_SLEEP: begin
                issue    = 1'b1;
                go_write = 1'b1;
                go_wdata = pack_ctl(mute_q, byp_q, SLP_FORCE, mode_q);
            end
            ST_WR_MODE: begin
                issue    = 1'b1;
                go_write = 1'b1;
                go_wdata = pack_ctl(mute_q, byp_q, SLP_FORCE, tgt_q);
            end
            ST_WR_RESTORE: begin
                issue    = 1'b1;
                go_write = 1'b1;
                go_wdata = pack_ctl(mute_q, byp_q, RESTORE_SLEEP, mode_q);
            end
            default: issue = 1'b0;
        endcase
        go = issue && port_idle;
    end

    // Start the poll interval or the sleep hold on the matching transitions.
    always_comb begin
        tmr_load = 1'b0;
        tmr_val  = '0;
        if ((state_q == ST_DECIDE && !act) || (state_q == ST_WR_RESTORE && done)) begin
            tmr_load = 1'b1;
            tmr_val  = TW'(POLL_CYCLES);
        end else if (state_q == ST_WR_MODE && done) begin
            tmr_load = 1'b1;
            tmr_val  = TW'(HOLD_CYCLES);
        end
    end

    // Sequence polls and switch sequences; capture poll results.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q   <= ST_POLL;
            mode_q    <= 1'b0;
            tgt_q     <= 1'b0;
            carrier_q <= 1'b0;
            mute_q    <= 1'b0;
            byp_q     <= 1'b0;
            cli_q     <= '0;
        end else begin
            unique case (state_q)
                ST_POLL: if (tmr_zero) state_q <= ST_RD_CTL;
                ST_RD_CTL: if (done) begin
                    carrier_q <= rd_data[CD_BIT];
                    mute_q    <= rd_data[MUTE_BIT];
                    byp_q     <= rd_data[BYP_BIT];
                    state_q   <= ST_RD_CLI;
                end
                ST_RD_CLI: if (done) begin
                    cli_q   <= rd_data[CLI_LSB +: CLI_W];
                    state_q <= ST_DECIDE;
                end
                ST_DECIDE: begin
                    if (act) begin
                        tgt_q   <= want;
                        state_q <= ST_WR_SLEEP;
                    end else begin
                        state_q <= ST_POLL;
                    end
                end
                ST_WR_SLEEP: if (done) state_q <= ST_WR_MODE;
                ST_WR_MODE: if (done) begin
                    mode_q  <= tgt_q;
                    state_q <= ST_HOLD;
                end
                ST_HOLD: if (tmr_zero) state_q <= ST_WR_RESTORE;
                ST_WR_RESTORE: if (done) state_q <= ST_POLL;
                default: state_q <= ST_POLL;
            endcase
        end
    end

    assign busy = (state_q == ST_WR_SLEEP) || (state_q == ST_WR_MODE) ||
                  (state_q == ST_HOLD) || (state_q == ST_WR_RESTORE);
    assign ext_mode = mode_q;

    // R8
    mode_change_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(mode_q) |-> $past(busy));
    // R3
    entry_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(busy) && !mode_q) |-> (carrier_q && cli_q < CLI_LIMIT));
    // R6
    exit_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(busy) && mode_q) |-> !carrier_q);
    // R5
    hold_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_req && cmd_write && cmd_wdata[SLP_LSB +: 2] != SLP_FORCE) |-> tmr_zero);
endmodule

// File: tb/tb_erc_supervisor.sv
module tb_erc_supervisor;
    localparam int POLL = 20;
    localparam int HOLD = 200;
    localparam int LAT  = 3;
    localparam logic [1:0] RST_SLP = 2'b01;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic cmd_req, cmd_write, cmd_ack, ext_mode, busy;
    logic [6:0] cmd_addr;
    logic [7:0] cmd_wdata, cmd_rdata;

    always #2 clk = ~clk;

    erc_supervisor #(.CLI_LIMIT(5'd18), .RESTORE_SLEEP(RST_SLP),
                     .POLL_CYCLES(POLL), .HOLD_CYCLES(HOLD)) dut (
        .clk(clk), .rst_n(rst_n), .cmd_req(cmd_req), .cmd_write(cmd_write),
        .cmd_addr(cmd_addr), .cmd_wdata(cmd_wdata), .cmd_ack(cmd_ack),
        .cmd_rdata(cmd_rdata), .ext_mode(ext_mode), .busy(busy)
    );

    int checks = 0, errors = 0, cyc = 0;
    bit finished = 0;
    // receiver register model
    bit carrier = 0, mute = 0, byp = 0, ext = 0;
    logic [1:0] slp = 2'b01;
    logic [4:0] cli = 5'd5;
    // sequence model
    int phase = 0, idle_start = -1, hold_start = -1, wcnt = 0;
    int entries = 0, exits = 0;
    bit m_cd, m_mute, m_byp, tgt, pend = 0, prev_req = 0;
    logic [7:0] pend_data, prev_wd;
    logic [6:0] prev_addr;
    bit prev_wr;

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic logic [7:0] ctl(input bit mu, input bit by, input logic [1:0] s, input bit e);
        return {1'b0, mu, by, s, e, 2'b00};
    endfunction

    // Receiver/SPI-master model and per-cycle reference comparison.
    initial begin
        cmd_ack = 0;
        cmd_rdata = '0;
        forever begin
            @(negedge clk);
            cyc++;
            if (!rst_n) begin
                // R1
                chk(!cmd_req && !ext_mode && !busy, "R1 reset outputs",
                    {cmd_req, ext_mode, busy}, 0);
                continue;
            end
            if (cmd_ack) begin
                cmd_ack = 0;
                if (pend) begin
                    mute = pend_data[6]; byp = pend_data[5];
                    slp = pend_data[4:3]; ext = pend_data[2];
                    pend = 0;
                end
            end
            // R8 mode and busy against model
            chk(ext_mode == ext, "R8 ext_mode", ext_mode, ext);
            if (slp == 2'b10) chk(busy == 1'b1, "R8 busy while asleep", busy, 1);
            if (phase < 2) chk(busy == 1'b0, "R8 busy while polling", busy, 0);
            // R9 stability
            if (prev_req && cmd_req)
                chk(cmd_addr == prev_addr && cmd_wdata == prev_wd && cmd_write == prev_wr,
                    "R9 request stable", {cmd_write, cmd_addr, cmd_wdata},
                    {prev_wr, prev_addr, prev_wd});
            if (cmd_req) begin
                if (wcnt == 0) begin
                    if (phase == 0 && idle_start >= 0)
                        chk(cyc - idle_start >= POLL, "R2 poll gap", cyc - idle_start, POLL);
                    if (phase == 4)
                        chk(cyc - hold_start >= HOLD, "R5 hold gap", cyc - hold_start, HOLD);
                end
                wcnt++;
                if (wcnt == LAT) begin
                    wcnt = 0;
                    cmd_ack = 1;
                    case (phase)
                        0: begin
                            chk(!cmd_write && cmd_addr == 7'h00, "R2 read 00h", {cmd_write, cmd_addr}, 0);
                            cmd_rdata = {carrier, mute, byp, slp, ext, 2'b00};
                            m_cd = carrier; m_mute = mute; m_byp = byp;
                            phase = 1;
                        end
                        1: begin
                            chk(!cmd_write && cmd_addr == 7'h03, "R2 read 03h", {cmd_write, cmd_addr}, 3);
                            cmd_rdata = {cli, 3'b000};
                            if (!ext && m_cd && cli < 5'd18) begin
                                tgt = 1; phase = 2; entries++;
                            end else if (ext && !m_cd) begin
                                tgt = 0; phase = 2; exits++;
                            end else begin
                                phase = 0; idle_start = cyc;
                            end
                        end
                        2, 3, 4: begin
                            logic [7:0] exp_wd;
                            if (phase == 2) exp_wd = ctl(m_mute, m_byp, 2'b10, ext);
                            else if (phase == 3) exp_wd = ctl(m_mute, m_byp, 2'b10, tgt);
                            else exp_wd = ctl(m_mute, m_byp, RST_SLP, tgt);
                            chk(cmd_write && cmd_addr == 7'h00, "R4 write 00h", {cmd_write, cmd_addr}, 128);
                            chk(cmd_wdata == exp_wd, "R4 R7 write data", cmd_wdata, exp_wd);
                            pend = 1; pend_data = cmd_wdata;
                            if (phase == 3) hold_start = cyc;
                            if (phase == 4) begin phase = 0; idle_start = cyc; end
                            else phase++;
                        end
                        default: ;
                    endcase
                end
            end
            prev_req = cmd_req; prev_addr = cmd_addr; prev_wd = cmd_wdata; prev_wr = cmd_write;
        end
    end

    task automatic settle(input bit m);
        int n = 0;
        while (!(ext_mode == m && !busy && phase < 2) && n < 5000) begin
            @(negedge clk); n++;
        end
        chk(n < 5000, "R3 R6 settle timeout", n, 5000);
    endtask

    task automatic summary;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            checks++; errors++;
            $display("FAIL watchdog actual=%0d expected=%0d", cyc, 0);
            summary();
        end
    end

    initial begin
        int e0;
        repeat (5) @(negedge clk);
        rst_n = 1;
        // R3: no carrier, short cable -> stays normal
        repeat (200) @(negedge clk);
        chk(ext_mode == 0 && entries == 0, "R3 no carrier", ext_mode, 0);
        // R3: carrier, code at limit -> stays normal
        carrier = 1; cli = 5'd18;
        repeat (200) @(negedge clk);
        chk(ext_mode == 0 && entries == 0, "R3 code at limit", ext_mode, 0);
        // R3 R4 R5: code just below limit -> entry
        cli = 5'd17;
        settle(1);
        chk(ext_mode == 1 && entries == 1, "R3 entry below limit", entries, 1);
        chk(slp == RST_SLP, "R4 sleep restored", slp, RST_SLP);
        // R6: long cable with carrier keeps extended mode
        cli = 5'd25;
        repeat (300) @(negedge clk);
        chk(ext_mode == 1 && exits == 0, "R6 stays extended", ext_mode, 1);
        // R6 R7: mute and bypass preserved through exit
        mute = 1; byp = 1;
        repeat (100) @(negedge clk);
        carrier = 0;
        settle(0);
        chk(exits == 1 && mute && byp, "R6 R7 exit keeps mute/bypass", {mute, byp}, 3);
        // Overlap: carrier lost during entry sequence
        mute = 0; byp = 0; cli = 5'd0; carrier = 1;
        e0 = exits;
        wait (busy);
        carrier = 0;
        settle(1);
        settle(0);
        chk(entries == 2 && exits == e0 + 1, "R6 exit after interrupted entry", exits, e0 + 1);
        chk(!cmd_req || phase < 2, "R2 idle after sequences", phase, 0);
        repeat (100) @(negedge clk);
        finished = 1;
        summary();
    end
endmodule